// File: doc/BRIEF.md
# Shared-Count GPIO Port Debouncer

This block cleans up the inputs of one eight-pin general-purpose I/O port. Every pin is first passed through a two-flop synchroniser. A pin can be set to use the debounce filter. In that case its filtered output changes only after the synchronised input has kept a new level for a programmed number of millisecond ticks. A pin that is not set to filter passes its synchronised input to the output after one more register stage.

All pins of the port share one 8-bit count register. It holds the stable time in milliseconds, from 1 to 255. Each pin has its own enable bit. Software sets the enable bits with a masked write. The upper byte of the data selects which bits change. The lower byte gives their new values. A prescaler derived from the clock frequency produces a single-cycle pulse once per millisecond, and all per-pin stability counters advance on that pulse. Writing the count register restarts every stability count that is in progress. A count of zero turns filtering off for the whole port.

Top module: `port_debouncer`

## Requirements
- R1: After reset, every filtered output is 0, every enable bit is 0 and the count register reads 0.
- R2: A write to the enable address (0xB0 + 4×PORT_IDX) changes enable bit i only where data bit 8+i is 1, and sets it to data bit i. Enable bits whose mask bit is 0 keep their value. A read of that address returns the enable bits in [7:0] and zeros in [15:8].
- R3: A write to the count address (0xF0 + 4×PORT_IDX) loads data bits [7:0] into the shared count. A read returns the count zero-extended to 16 bits. Writes to any other address leave the count unchanged.
- R4: A pin whose enable bit is 0 shows its raw input on its filtered output three clock cycles later, with no filtering.
- R5: While the count is 0, every pin passes through as in R4, whatever its enable bit.
- R6: For an enabled pin with count N > 0, the filtered output keeps its old value while the new raw level has been held for fewer than N−1 millisecond periods. It takes the new level within N millisecond periods plus three cycles.
- R7: A raw pulse shorter than N−1 millisecond periods on an enabled pin never reaches the filtered output.
- R8: Any write to the count register restarts the stability count of every enabled pin. After the write, the new level must again be held for the full time given in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wr_data | input | 2×PINS | Write data (mask in upper half for enables) |
| rd_data | output | 2×PINS | Combinational read data for `addr` |
| pin_raw | input | PINS | Asynchronous raw pin inputs |
| pin_filt | output | PINS | Filtered pin levels |

## Verification
On every cycle, the assertions check four things. An active pin's output moves only on a millisecond pulse. A stability counter always stays below the shared count. A count write leaves all stability counters at zero. A pass-through pin follows its synchroniser exactly. Only the bench scenarios can show the behaviour from end to end. These scenarios cover masked-write merges over many mask and value patterns, the hold-off windows for a range of counts, glitch rejection, and the restart caused by rewriting the count. Each of these depends on the sequence of stimulus over many milliseconds, not on any single cycle.

// File: rtl/port_debouncer.sv
module port_debouncer #(
  parameter int PINS     = 8,
  parameter int CNT_W    = 8,
  parameter int CLK_HZ   = 50_000_000,
  parameter int PORT_IDX = 0,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*PINS-1:0]   wr_data,
  output logic [2*PINS-1:0]   rd_data,
  input  logic [PINS-1:0]     pin_raw,
  output logic [PINS-1:0]     pin_filt
);
  localparam int TICK_CYCLES = (CLK_HZ / 1000) < 1 ? 1 : CLK_HZ / 1000;
  localparam int PRE_W       = $clog2(TICK_CYCLES + 1);
  localparam logic [ADDR_W-1:0] COUNT_ADDR  = ADDR_W'(8'hF0 + 4 * PORT_IDX);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(8'hB0 + 4 * PORT_IDX);

  logic [PINS-1:0]  meta, sync, en, act;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] stab [PINS];
  logic [PRE_W-1:0] pre;
  logic             tick;

  wire cnt_wr = wr_en && (addr == COUNT_ADDR);
  wire en_wr  = wr_en && (addr == ENABLE_ADDR);
  wire [PINS-1:0] wmask = wr_data[2*PINS-1:PINS];
  wire [PINS-1:0] wval  = wr_data[PINS-1:0];

  assign tick = (pre == PRE_W'(TICK_CYCLES - 1));
  assign act  = en & {PINS{cnt != '0}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      en   <= '0;
      cnt  <= '0;
      pre  <= '0;
    end else begin
      meta <= pin_raw;
      sync <= meta;
      pre  <= tick ? '0 : pre + 1'b1;
      if (en_wr)  en  <= (en & ~wmask) | (wval & wmask);
      if (cnt_wr) cnt <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PINS; i++) begin
      if (!rst_n) begin
        pin_filt[i] <= 1'b0;
        stab[i]     <= '0;
      end else if (!act[i]) begin
        pin_filt[i] <= sync[i];
        stab[i]     <= '0;
      end else if (cnt_wr || sync[i] == pin_filt[i]) begin
        stab[i] <= '0;
      end else if (tick) begin
        if (stab[i] + CNT_W'(1) >= cnt) begin
          pin_filt[i] <= sync[i];
          stab[i]     <= '0;
        end else begin
          stab[i] <= stab[i] + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == COUNT_ADDR)       rd_data[CNT_W-1:0] = cnt;
    else if (addr == ENABLE_ADDR) rd_data[PINS-1:0]  = en;
  end

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ENABLE_ADDR) |-> (rd_data[2*PINS-1:PINS] == '0));

  if (TICK_CYCLES > 1) begin : g_tick_chk
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin_chk
    assert_hold_off_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act[g] && !tick) |=> $stable(pin_filt[g]));
    assert_stab_below_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act[g] |-> (stab[g] < cnt));
    assert_restart_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (stab[g] == '0));
    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !act[g] |=> (pin_filt[g] == $past(sync[g])));
  end
endmodule

// File: tb/port_debouncer_test.sv
module port_debouncer_test;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 8;
  localparam int PORT       = 2;
  localparam logic [7:0] CA = 8'hF0 + 4 * PORT;
  localparam logic [7:0] EA = 8'hB0 + 4 * PORT;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0, pin_raw = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic [7:0] pin_filt;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_debouncer #(.PINS(8), .CNT_W(8), .CLK_HZ(T * 1000), .PORT_IDX(PORT), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_raw(pin_raw), .pin_filt(pin_filt));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; #1 d = rd_data;
  endtask

  initial begin
    logic [15:0] r;
    logic [7:0] model, m, v;
    bit old;
    @(negedge clk); cyc(2); rst_n = 1; cyc(1);

    rd(CA, r); check(r == 0, "R1 count", r, 0);
    rd(EA, r); check(r == 0, "R1 enable", r, 0);
    check(pin_filt == 0, "R1 filt", pin_filt, 0);

    wr(8'hF0, 16'h0033); rd(CA, r); check(r == 0, "R3 other address", r, 0);
    wr(CA, 16'hAB17); rd(CA, r); check(r == 16'h0017, "R3 load", r, 16'h17);
    wr(CA, 16'h0000);

    model = 0;
    for (int k = 0; k < 16; k++) begin
      m = 8'((k * 37 + 5) & 255); v = 8'((k * 91 + 3) & 255);
      if (k == 7) m = 0;
      wr(EA, {m, v});
      model = (model & ~m) | (v & m);
      rd(EA, r); check(r == {8'h00, model}, "R2 masked merge", r, {8'h00, model});
    end

    wr(EA, 16'hFF00); wr(CA, 16'h0003);
    for (int p = 0; p < 256; p += 17) begin
      pin_raw = 8'(p); cyc(2); #1;
      check(pin_filt != 8'(p) || p == 0 || p == 255 && 0, "R4 not early", pin_filt, p);
      cyc(1); #1; check(pin_filt == 8'(p), "R4 pass", pin_filt, p);
    end

    wr(CA, 16'h0000); wr(EA, 16'hFFFF);
    for (int p = 255; p >= 0; p -= 15) begin
      pin_raw = 8'(p); cyc(4); #1; check(pin_filt == 8'(p), "R5 zero count pass", pin_filt, p);
    end

    pin_raw = 0; wr(EA, 16'hFF00); cyc(4);
    wr(EA, 16'h0101);
    for (int n = 1; n <= 5; n++) begin
      wr(CA, 16'(n)); cyc(2);
      old = pin_filt[0];
      pin_raw[0] = ~old;
      if (n > 1) begin
        cyc((n - 1) * T); #1;
        check(pin_filt[0] == old, "R6 held off", pin_filt[0], old);
        cyc(T + 3);
      end else cyc(T + 3);
      #1 check(pin_filt[0] == !old, "R6 taken", pin_filt[0], !old);
      check(pin_filt[7:1] == 0, "R6 others", pin_filt[7:1], 0);
    end

    wr(CA, 16'd4); cyc(2);
    old = pin_filt[0];
    pin_raw[0] = ~old; cyc(2 * T); pin_raw[0] = old;
    cyc(6 * T); #1 check(pin_filt[0] == old, "R7 glitch", pin_filt[0], old);

    pin_raw[0] = ~old; cyc(2 * T);
    wr(CA, 16'd4);
    cyc(3 * T - 1); #1 check(pin_filt[0] == old, "R8 restarted", pin_filt[0], old);
    cyc(T + 4); #1 check(pin_filt[0] == !old, "R8 settles", pin_filt[0], !old);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule